// File: doc/BRIEF.md
# Timer Target Compare Event Generator

The block watches a free-running 64-bit time value and compares it on every clock with a programmable 64-bit target. When the time has reached the target, the block raises a one-cycle compare event, sets a sticky interrupt status bit, and moves the target forward without software help. In reload mode it copies a 64-bit reload word pair into the target. In add mode it adds the 32-bit low reload word to the target.

Each of two event outputs has its own 2-bit mode. A channel can give a fixed-length pulse, toggle on each of its events, follow the interrupt status, or stay inactive. Each channel also has a polarity bit and an output-enable bit. Software reaches the registers through a plain write strobe and a read strobe with a small word address. The time counter and its rate control sit outside the block.

Top module: `tgt_event_gen`

## Requirements
- R1: At each rising clock edge, `hit` is true when `time_now >= target`, compared as unsigned 64-bit values. `evt` is high in the cycle that follows every edge at which `hit` was true. After reset the target is all ones.
- R2: When control bit 0 is 0 (reload mode), an event with no target write in the same cycle loads the target with {reload high, reload low}.
- R3: When control bit 0 is 1 (add mode), an event with no target write in the same cycle adds the zero-extended reload low word to the 64-bit target. The carry passes from the low word into the high word, and the sum wraps modulo 2^64.
- R4: A write to target address 0 or 1 in the same cycle as an event replaces the written word and cancels the automatic update for that cycle. The other target word keeps its value.
- R5: The interrupt status (`irq`, status address 5 bit 0) is set by every event. Writing 1 to bit 0 clears it. If a set and a clear fall in the same cycle, the set wins. The status resets to 0.
- R6: Channel mode 00 gives a pulse that lasts max(1, floor(PULSE_NS/CLK_PERIOD_NS)) cycles after the event edge. An event during a pulse restarts the full length.
- R7: Channel mode 01 gives a level that inverts on each event that occurs while the channel is in mode 01.
- R8: Channel mode 10 gives a level that follows the interrupt status.
- R9: Channel mode 11 gives an inactive level.
- R10: When a channel's output-enable bit is 0, its `gpio_oe` bit and its `gpio_out` bit are both 0. When the enable bit is 1, `gpio_oe` is 1.
- R11: When a channel's polarity bit is 1, the channel's level is inverted before it reaches `gpio_out`.
- R12: Register map, read as `rdata` while `rd_en` is high (0 otherwise): address 0 target low, 1 target high, 2 reload low, 3 reload high, 4 control, 5 status. Control layout: bit 0 add mode, bits 2:1 channel 0 mode, bits 4:3 channel 1 mode, bit 5 channel 0 polarity, bit 6 channel 1 polarity, bit 7 channel 0 enable, bit 8 channel 1 enable. The reload words and the control register reset to 0. A write takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_now | input | 64 | Free-running time value |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| evt | output | 1 | One-cycle compare event |
| irq | output | 1 | Sticky interrupt status |
| gpio_out | output | 2 | Event output levels after polarity and gating |
| gpio_oe | output | 2 | Event output drive enables |

## Verification
The target-update checks take for granted that no software write to a target word lands in the cycle they examine. The toggle check takes for granted that the control register is not rewritten in the cycle of the event it watches. The stimulus meets both conditions outside a few chosen windows. There it deliberately writes the target while the target lies in the past and events repeat every cycle, and there it writes the clear bit while events keep arriving, so that the write-priority and set-wins paths are covered. The time input mostly advances by one per cycle. Jumps are made only to reach the low-word carry and the 64-bit wrap, and the model in the bench follows each jump.

// File: rtl/tgt_event_gen.sv
module tgt_event_gen #(
  parameter int CLK_PERIOD_NS = 40,
  parameter int PULSE_NS      = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] time_now,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        evt,
  output logic        irq,
  output logic [1:0]  gpio_out,
  output logic [1:0]  gpio_oe
);
  localparam int PULSE_RAW = PULSE_NS / CLK_PERIOD_NS;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int CW        = $clog2(PULSE_CYC + 1);

  logic [63:0]   tgt;
  logic [31:0]   rld_lo, rld_hi;
  logic          add_mode;
  logic [1:0]    mode [2];
  logic [1:0]    pol, oe, tog;
  logic          irq_sts;
  logic [CW-1:0] pcnt;

  wire hit     = time_now >= tgt;
  wire wr_tlo  = wr_en && addr == 3'd0;
  wire wr_thi  = wr_en && addr == 3'd1;
  wire tgt_wr  = wr_tlo || wr_thi;
  wire wr_ctl  = wr_en && addr == 3'd4;
  wire clr_irq = wr_en && addr == 3'd5 && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt      <= '1;
      rld_lo   <= '0;
      rld_hi   <= '0;
      add_mode <= 1'b0;
      mode[0]  <= 2'b00;
      mode[1]  <= 2'b00;
      pol      <= '0;
      oe       <= '0;
      tog      <= '0;
      irq_sts  <= 1'b0;
      pcnt     <= '0;
      evt      <= 1'b0;
    end else begin
      if (tgt_wr) begin
        if (wr_tlo) tgt[31:0]  <= wdata;
        if (wr_thi) tgt[63:32] <= wdata;
      end else if (hit) begin
        tgt <= add_mode ? tgt + {32'd0, rld_lo} : {rld_hi, rld_lo};
      end
      if (wr_en && addr == 3'd2) rld_lo <= wdata;
      if (wr_en && addr == 3'd3) rld_hi <= wdata;
      if (wr_ctl) begin
        add_mode <= wdata[0];
        mode[0]  <= wdata[2:1];
        mode[1]  <= wdata[4:3];
        pol      <= wdata[6:5];
        oe       <= wdata[8:7];
      end
      for (int i = 0; i < 2; i++)
        if (hit && mode[i] == 2'b01) tog[i] <= ~tog[i];
      if (hit)          irq_sts <= 1'b1;
      else if (clr_irq) irq_sts <= 1'b0;
      if (hit)               pcnt <= CW'(PULSE_CYC);
      else if (pcnt != '0)   pcnt <= pcnt - 1'b1;
      evt <= hit;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        3'd0: rdata = tgt[31:0];
        3'd1: rdata = tgt[63:32];
        3'd2: rdata = rld_lo;
        3'd3: rdata = rld_hi;
        3'd4: rdata = {23'd0, oe, pol, mode[1], mode[0], add_mode};
        3'd5: rdata = {31'd0, irq_sts};
        default: rdata = '0;
      endcase
  end

  assign irq     = irq_sts;
  assign gpio_oe = oe;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic lvl;
    always_comb
      case (mode[i])
        2'b00:   lvl = pcnt != '0;
        2'b01:   lvl = tog[i];
        2'b10:   lvl = irq_sts;
        default: lvl = 1'b0;
      endcase
    assign gpio_out[i] = oe[i] & (lvl ^ pol[i]);

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode[i] == 2'b01) |=> (tog[i] != $past(tog[i]))); // R7
  end

  AST_EVT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (evt && irq)); // R1
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !tgt_wr && !add_mode) |=> (tgt == {$past(rld_hi), $past(rld_lo)})); // R2
  AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !tgt_wr && add_mode) |=> (tgt == $past(tgt) + {32'd0, $past(rld_lo)})); // R3
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tlo |=> (tgt[31:0] == $past(wdata))); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_irq) |=> irq); // R5
  AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (pcnt == CW'(PULSE_CYC))); // R6
endmodule

// File: tb/sim_tgt_event_gen.sv
module sim_tgt_event_gen;
  localparam int CLKP = 10;
  localparam int PCYC = 100 / CLKP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] tnow = '0;
  logic tload = 1'b0;
  logic [63:0] tval = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic evt, irq;
  logic [1:0] gpio_out, gpio_oe;

  int n_cmp = 0, n_bad = 0, rot = 0;
  bit done = 0;

  always #(CLKP/2) clk = ~clk;

  always @(posedge clk) tnow <= tload ? tval : tnow + 64'd1;

  tgt_event_gen #(.CLK_PERIOD_NS(CLKP), .PULSE_NS(100)) u0 (
    .clk(clk), .rst_n(rst_n), .time_now(tnow), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe));

  logic [63:0] m_tgt;
  logic [31:0] m_rlo, m_rhi;
  logic m_add, m_irq, m_evt;
  logic [1:0] m_mode [2];
  logic [1:0] m_pol, m_oe, m_tog;
  int m_pcnt;
  string tlab = "R1";

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic lvl(int ch);
    case (m_mode[ch])
      2'b00: return m_pcnt != 0;
      2'b01: return m_tog[ch];
      2'b10: return m_irq;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string olab(int ch);
    if (!m_oe[ch]) return "R10";
    if (m_pol[ch]) return "R11";
    case (m_mode[ch])
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tgt = '1; m_rlo = 0; m_rhi = 0; m_add = 0; m_irq = 0; m_evt = 0;
      m_mode[0] = 0; m_mode[1] = 0; m_pol = 0; m_oe = 0; m_tog = 0; m_pcnt = 0;
      tlab = "R1";
    end else begin
      logic hit, twr;
      logic [63:0] nt;
      hit = tnow >= m_tgt;
      twr = wr_en && (addr == 3'd0 || addr == 3'd1);
      nt = m_tgt;
      if (wr_en && addr == 3'd0) nt[31:0] = wdata;
      if (wr_en && addr == 3'd1) nt[63:32] = wdata;
      if (hit && twr) tlab = "R4";
      else if (hit) begin
        nt = m_add ? m_tgt + {32'd0, m_rlo} : {m_rhi, m_rlo};
        tlab = m_add ? "R3" : "R2";
      end
      for (int c = 0; c < 2; c++) if (hit && m_mode[c] == 2'b01) m_tog[c] = ~m_tog[c];
      m_tgt = nt;
      if (wr_en && addr == 3'd2) m_rlo = wdata;
      if (wr_en && addr == 3'd3) m_rhi = wdata;
      if (wr_en && addr == 3'd4) begin
        m_add = wdata[0]; m_mode[0] = wdata[2:1]; m_mode[1] = wdata[4:3];
        m_pol = wdata[6:5]; m_oe = wdata[8:7];
      end
      if (hit) m_irq = 1;
      else if (wr_en && addr == 3'd5 && wdata[0]) m_irq = 0;
      if (hit) m_pcnt = PCYC;
      else if (m_pcnt > 0) m_pcnt--;
      m_evt = hit;
    end
    #1;
    check("R1", evt, m_evt);
    check("R5", irq, m_irq);
    for (int c = 0; c < 2; c++) begin
      check("R10", gpio_oe[c], m_oe[c]);
      check(olab(c), gpio_out[c], m_oe[c] & (lvl(c) ^ m_pol[c]));
    end
    if (!rd_en) check("R12", rdata, 0);
    else case (addr)
      3'd0: check(tlab, rdata, m_tgt[31:0]);
      3'd1: check(tlab, rdata, m_tgt[63:32]);
      3'd2: check("R12", rdata, m_rlo);
      3'd3: check("R12", rdata, m_rhi);
      3'd4: check("R12", rdata, {23'd0, m_oe, m_pol, m_mode[1], m_mode[0], m_add});
      3'd5: check("R5", rdata, {31'd0, m_irq});
      default: check("R12", rdata, 0);
    endcase
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 0; rd_en = 1; addr = 3'(rot % 6); rot++;
    end
  endtask

  task automatic jump(logic [63:0] v);
    @(negedge clk);
    tload = 1; tval = v;
    @(negedge clk);
    tload = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(8);                                  // R12 reset values
    wr(3'd2, 32'd200); wr(3'd3, 0);
    wr(3'd4, 32'h188);                         // R2 reload, ch0 pulse, ch1 toggle
    wr(3'd1, 0); wr(3'd0, 32'(tnow) + 20);
    idle(60);
    wr(3'd4, 32'h189); wr(3'd2, 32'd15);        // R3 add mode, period 15
    wr(3'd0, 32'(tnow) + 5);
    idle(70);
    wr(3'd2, 32'd6);                           // R6 restart
    idle(30);
    wr(3'd4, 32'h1DD);                         // R8 ch0 irq, R9 ch1 reserved, R11 ch1 pol
    idle(20);
    wr(3'd2, 32'd1); idle(4);
    wr(3'd5, 32'd1);                           // R5 set wins over clear
    idle(4);
    wr(3'd2, 32'd1000); idle(4);
    wr(3'd5, 32'd1); idle(10);                 // R5 clear
    wr(3'd4, 32'h009); idle(10);               // R10 outputs released
    wr(3'd4, 32'h1A9);                         // R11 ch0 pol, pulse
    jump(64'h0000_0000_FFFF_FFF0);
    wr(3'd1, 0); wr(3'd0, 32'hFFFF_FFF8); wr(3'd2, 32'h20);   // R3 carry
    idle(60);
    jump(64'hFFFF_FFFF_FFFF_FFC0);
    wr(3'd1, 32'hFFFF_FFFF); wr(3'd0, 32'hFFFF_FFD0);        // R3 wrap
    idle(60);
    wr(3'd4, 32'h188); wr(3'd2, 32'd5); wr(3'd3, 0);
    wr(3'd1, 0); wr(3'd0, 32'd7); idle(5);
    wr(3'd0, 32'd1000);                        // R4 write during event
    wr(3'd1, 32'h10);                          // R4
    idle(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule